// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches received frames one byte per cycle and decides, for each frame, whether the capture unit should keep a timestamp for it. It accepts layer-2 precision-time frames, recognised by EtherType, and layer-4 ones carried in IPv4/UDP to the event port. The frame's UDP source port may also be required to be the event port. After that the PTP version and message kind are matched against a configured mode.

Frames are presented as a byte stream with a first-byte and a last-byte marker. Untagged Ethernet II is assumed, so the EtherType sits at bytes 12 and 13. The IPv4 header length is taken from its IHL field, which places the UDP header and then the PTP header. For every frame the block raises one single-cycle verdict pulse, together with a hit flag. The pulse comes as soon as the deciding byte has been seen, and in any case by the cycle after the frame's last byte.

Top module: `ptp_evt_classifier`

## Requirements
- R1: After reset, and while no frame bytes arrive, `res_vld` and `res_hit` stay low.
- R2: Each frame, which starts with the byte marked `s_first` and ends with the byte marked `s_last`, produces exactly one `res_vld` pulse one cycle long. The pulse comes in the cycle after the byte that settles the verdict and never later than the cycle after the last byte.
- R3: Mode code 4 gives a hit for every frame, one-byte frames included. Mode codes 0, 5, 6 and 7 give a verdict with `res_hit` low for every frame.
- R4: A frame whose bytes 12 to 13 (high byte first) equal 0x88F7 is a layer-2 candidate only when `cfg_l2_en` is 1 and the mode is 3. Otherwise it gets no hit.
- R5: A frame is a layer-4 candidate only when all of these hold: `cfg_l4_en` is 1; the EtherType is 0x0800; the upper nibble of byte 14 is 4; the IHL, the lower nibble of byte 14, is at least 5; byte 23 is 17. The UDP header then starts at byte 14+4*IHL, and its destination port, bytes 2 to 3 high byte first, must equal 319.
- R6: When `cfg_sport_chk` is 1, a layer-4 candidate also needs its UDP source port (UDP bytes 0 to 1) to equal 319. When it is 0, the source port has no effect.
- R7: In mode 3 the PTP header starts at byte 14 for layer 2 and at UDP start + 8 for layer 4. A hit needs the lower nibble of PTP byte 1 (version) to be 2 and the lower nibble of PTP byte 0 (message type) to be 0 to 3.
- R8: Modes 1 and 2 accept only layer-4 candidates. The version nibble must be 1, and PTP byte 32 (control) must be 0 in mode 1 (Sync) or 1 in mode 2 (Delay_Req).
- R9: A frame that ends before its deciding byte gets a verdict with `res_hit` low in the cycle after its last byte.
- R10: Any frame with another EtherType gets no hit in modes 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Frame byte valid this cycle |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the last of a frame |
| s_data | input | 8 | Frame byte |
| cfg_mode | input | 3 | 0 off, 1 V1 Sync, 2 V1 Delay_Req, 3 V2 events, 4 all frames |
| cfg_l2_en | input | 1 | Accept layer-2 EtherType frames |
| cfg_l4_en | input | 1 | Accept IPv4/UDP frames |
| cfg_sport_chk | input | 1 | Also require UDP source port match |
| res_vld | output | 1 | One-cycle verdict pulse per frame |
| res_hit | output | 1 | Verdict: timestamp this frame |

## Verification
The bench goes after the places where the header offset moves: an IHL of 6 shifts the UDP and PTP fields, and a design that used a fixed 20-byte IP header would read the port and control bytes from the wrong place and hit or miss wrongly. It sweeps message types across the 3/4 boundary and the version nibble, so that a loose range check or a V1 frame slipping into mode 3 turns into a wrong hit. It cuts one layer-4 frame off at every length, which shows a design that gives no verdict, or gives two, when a frame ends early. It also runs every mode code with every enable combination, so that a source-port check left on while disabled, or a layer-2 frame accepted in a V1 mode, shows up as a wrong verdict.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  typedef enum logic [2:0] {
    MD_OFF     = 3'd0,
    MD_V1_SYNC = 3'd1,
    MD_V1_DREQ = 3'd2,
    MD_V2_EVT  = 3'd3,
    MD_ALL     = 3'd4
  } mode_e;

  localparam int ETH_TYPE_HI_OFS = 12;
  localparam int ETH_TYPE_LO_OFS = 13;
  localparam int IP_VIHL_OFS     = 14;
  localparam int IP_PROTO_OFS    = 23;
  localparam int UDP_HDR_LEN     = 8;
  localparam int V1_CTRL_OFS     = 32;
endpackage

// File: rtl/ptpc_pos.sv
module ptpc_pos #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_first,
  output logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign idx = s_first ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (s_valid && (idx != {CNT_W{1'b1}})) cnt_d = idx + CNT_W'(1);
    else if (s_valid) cnt_d = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (s_valid) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ptpc_fields.sv
module ptpc_fields
  import ptpc_pkg::*;
#(
  parameter int          CNT_W     = 7,
  parameter logic [15:0] ETYPE_PTP = 16'h88F7,
  parameter logic [15:0] ETYPE_IP4 = 16'h0800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic [CNT_W-1:0] idx,
  output logic [7:0]       prev_byte,
  output logic             is_l2,
  output logic             is_ip,
  output logic [CNT_W-1:0] udp_base,
  output logic [CNT_W-1:0] ptp_base
);
  localparam logic [CNT_W-1:0] IP_START = CNT_W'(IP_VIHL_OFS);
  localparam logic [CNT_W-1:0] UDP_LEN  = CNT_W'(UDP_HDR_LEN);

  logic [7:0] prev_q, prev_d;
  logic [3:0] ihl_q, ihl_d;
  logic       l2_q, l2_d, ip_q, ip_d;

  always_comb begin
    prev_d = prev_q;
    ihl_d  = ihl_q;
    l2_d   = l2_q;
    ip_d   = ip_q;
    if (s_valid) begin
      prev_d = s_data;
      if (idx == '0) begin
        l2_d = 1'b0;
        ip_d = 1'b0;
      end
      if (idx == CNT_W'(ETH_TYPE_LO_OFS)) begin
        l2_d = ({prev_q, s_data} == ETYPE_PTP);
        ip_d = ({prev_q, s_data} == ETYPE_IP4);
      end
      if (idx == IP_START) ihl_d = s_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ihl_q  <= '0;
      l2_q   <= 1'b0;
      ip_q   <= 1'b0;
    end else if (s_valid) begin
      prev_q <= prev_d;
      ihl_q  <= ihl_d;
      l2_q   <= l2_d;
      ip_q   <= ip_d;
    end
  end

  assign prev_byte = prev_q;
  assign is_l2     = l2_q;
  assign is_ip     = ip_q;
  assign udp_base  = IP_START + CNT_W'({ihl_q, 2'b00});
  assign ptp_base  = l2_q ? IP_START : (udp_base + UDP_LEN);
endmodule

// File: rtl/ptpc_verdict.sv
module ptpc_verdict
  import ptpc_pkg::*;
#(
  parameter int          CNT_W     = 7,
  parameter logic [15:0] ETYPE_PTP = 16'h88F7,
  parameter logic [15:0] ETYPE_IP4 = 16'h0800,
  parameter logic [7:0]  UDP_PROTO = 8'd17,
  parameter logic [15:0] EVT_PORT  = 16'd319
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_first,
  input  logic             s_last,
  input  logic [7:0]       s_data,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       prev_byte,
  input  logic             is_l2,
  input  logic             is_ip,
  input  logic [CNT_W-1:0] udp_base,
  input  logic [CNT_W-1:0] ptp_base,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_l2_en,
  input  logic             cfg_l4_en,
  input  logic             cfg_sport_chk,
  output logic             res_vld,
  output logic             res_hit
);
  mode_e       mode;
  logic        is_v1;
  logic        live;
  logic        dec, hit;
  logic        done_q, done_d;
  logic        vld_q, hit_q;
  logic [15:0] word;

  assign mode  = mode_e'(cfg_mode);
  assign is_v1 = (mode == MD_V1_SYNC) || (mode == MD_V1_DREQ);
  assign live  = s_valid && (s_first || !done_q);
  assign word  = {prev_byte, s_data};

  always_comb begin
    dec = 1'b0;
    hit = 1'b0;
    if (live) begin
      case (mode)
        MD_ALL: begin
          if (idx == '0) begin
            dec = 1'b1;
            hit = 1'b1;
          end
        end
        MD_V1_SYNC, MD_V1_DREQ, MD_V2_EVT: begin
          if (idx == CNT_W'(ETH_TYPE_LO_OFS)) begin
            if (word == ETYPE_PTP) dec = !(cfg_l2_en && (mode == MD_V2_EVT));
            else if (word == ETYPE_IP4) dec = !cfg_l4_en;
            else dec = 1'b1;
          end else if (idx > CNT_W'(ETH_TYPE_LO_OFS) && (is_ip || is_l2)) begin
            if (is_ip && idx == CNT_W'(IP_VIHL_OFS)) begin
              dec = (s_data[7:4] != 4'd4) || (s_data[3:0] < 4'd5);
            end else if (is_ip && idx == CNT_W'(IP_PROTO_OFS)) begin
              dec = (s_data != UDP_PROTO);
            end else if (is_ip && idx == udp_base + CNT_W'(1)) begin
              dec = cfg_sport_chk && (word != EVT_PORT);
            end else if (is_ip && idx == udp_base + CNT_W'(3)) begin
              dec = (word != EVT_PORT);
            end else if (idx == ptp_base + CNT_W'(1)) begin
              if (mode == MD_V2_EVT) begin
                dec = 1'b1;
                hit = (s_data[3:0] == 4'd2) && (prev_byte[3:0] < 4'd4);
              end else begin
                dec = (s_data[3:0] != 4'd1);
              end
            end else if (is_v1 && idx == ptp_base + CNT_W'(V1_CTRL_OFS)) begin
              dec = 1'b1;
              hit = (s_data == ((mode == MD_V1_SYNC) ? 8'd0 : 8'd1));
            end
          end
        end
        default: begin
          if (idx == '0) dec = 1'b1;
        end
      endcase
      if (s_last && !dec) begin
        dec = 1'b1;
        hit = 1'b0;
      end
    end
  end

  always_comb begin
    done_d = done_q;
    if (s_valid) done_d = dec ? 1'b1 : (s_first ? 1'b0 : done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      if (s_valid) done_q <= done_d;
      vld_q <= dec;
      hit_q <= dec && hit;
    end
  end

  assign res_vld = vld_q;
  assign res_hit = hit_q;

  // R2: a verdict is never repeated unless a new frame begins
  p_single_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !(s_valid && s_first)) |=> !res_vld);

  // R2: an undecided frame is settled by the cycle after its last byte
  p_last_settles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_last && (s_first || !done_q)) |=> res_vld);

  // R3: the all-frames mode hits on the first byte
  p_all_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_first && cfg_mode == 3'd4) |=> (res_vld && res_hit));

  // R3: off and unused codes never hit
  p_off_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && ($past(cfg_mode) == 3'd0 || $past(cfg_mode) > 3'd4)) |-> !res_hit);

  // R8: a V1 hit only comes from an IPv4 frame
  p_v1_needs_ip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && ($past(cfg_mode) == 3'd1 || $past(cfg_mode) == 3'd2)) |-> $past(is_ip));

  // R1: a hit is always part of a verdict
  p_hit_in_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_vld);
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptpc_pkg::*;
#(
  parameter int          CNT_W     = 7,
  parameter logic [15:0] ETYPE_PTP = 16'h88F7,
  parameter logic [15:0] ETYPE_IP4 = 16'h0800,
  parameter logic [7:0]  UDP_PROTO = 8'd17,
  parameter logic [15:0] EVT_PORT  = 16'd319
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  input  logic       s_first,
  input  logic       s_last,
  input  logic [7:0] s_data,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_l2_en,
  input  logic       cfg_l4_en,
  input  logic       cfg_sport_chk,
  output logic       res_vld,
  output logic       res_hit
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [CNT_W-1:0] idx;
  logic [7:0]       prev_byte;
  logic             is_l2, is_ip;
  logic [CNT_W-1:0] udp_base, ptp_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ptpc_pos #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_i_n), .s_valid(s_valid), .s_first(s_first), .idx(idx)
  );

  ptpc_fields #(.CNT_W(CNT_W), .ETYPE_PTP(ETYPE_PTP), .ETYPE_IP4(ETYPE_IP4)) u_fields (
    .clk(clk), .rst_n(rst_i_n), .s_valid(s_valid), .s_data(s_data), .idx(idx),
    .prev_byte(prev_byte), .is_l2(is_l2), .is_ip(is_ip),
    .udp_base(udp_base), .ptp_base(ptp_base)
  );

  ptpc_verdict #(.CNT_W(CNT_W), .ETYPE_PTP(ETYPE_PTP), .ETYPE_IP4(ETYPE_IP4),
                 .UDP_PROTO(UDP_PROTO), .EVT_PORT(EVT_PORT)) u_verdict (
    .clk(clk), .rst_n(rst_i_n), .s_valid(s_valid), .s_first(s_first), .s_last(s_last),
    .s_data(s_data), .idx(idx), .prev_byte(prev_byte), .is_l2(is_l2), .is_ip(is_ip),
    .udp_base(udp_base), .ptp_base(ptp_base), .cfg_mode(cfg_mode),
    .cfg_l2_en(cfg_l2_en), .cfg_l4_en(cfg_l4_en), .cfg_sport_chk(cfg_sport_chk),
    .res_vld(res_vld), .res_hit(res_hit)
  );
endmodule

// File: tb/ptp_evt_classifier_bench.sv
module ptp_evt_classifier_bench;
  logic       clk, rst_n;
  logic       s_valid, s_first, s_last;
  logic [7:0] s_data;
  logic [2:0] cfg_mode;
  logic       cfg_l2_en, cfg_l4_en, cfg_sport_chk;
  logic       res_vld, res_hit;

  int total, bad, pulses;
  logic last_hit;
  logic [7:0] fr [0:127];
  int fr_len;

  ptp_evt_classifier u_ptp_evt_classifier (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_first(s_first), .s_last(s_last),
    .s_data(s_data), .cfg_mode(cfg_mode), .cfg_l2_en(cfg_l2_en), .cfg_l4_en(cfg_l4_en),
    .cfg_sport_chk(cfg_sport_chk), .res_vld(res_vld), .res_hit(res_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (res_vld) begin
      pulses = pulses + 1;
      last_hit = res_hit;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d mode=%0d cfg=%0d%0d%0d len=%0d",
               req, act, exp, cfg_mode, cfg_l2_en, cfg_l4_en, cfg_sport_chk, fr_len);
    end
  endtask

  task automatic mk(input logic [15:0] et, input logic [7:0] b14, input logic [7:0] proto,
                    input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] p0,
                    input logic [7:0] p1, input logic [7:0] ctrl, input int len);
    int u, p;
    for (int i = 0; i < 128; i++) fr[i] = 8'h00;
    fr[12] = et[15:8]; fr[13] = et[7:0];
    u = 14 + 4 * int'(b14[3:0]);
    p = (et == 16'h88F7) ? 14 : u + 8;
    if (et != 16'h88F7) begin
      fr[14] = b14; fr[23] = proto;
      fr[u] = sp[15:8]; fr[u+1] = sp[7:0];
      fr[u+2] = dp[15:8]; fr[u+3] = dp[7:0];
    end
    fr[p] = p0; fr[p+1] = p1;
    if (p + 32 < 128) fr[p+32] = ctrl;
    fr_len = len;
  endtask

  function automatic bit model();
    logic [15:0] et;
    int ihl, u, p, md;
    md = int'(cfg_mode);
    if (md == 4) return 1'b1;
    if (md < 1 || md > 3) return 1'b0;
    if (fr_len < 14) return 1'b0;
    et = {fr[12], fr[13]};
    if (et == 16'h88F7) begin
      if (!cfg_l2_en || md != 3 || fr_len < 16) return 1'b0;
      return (fr[15][3:0] == 4'd2) && (fr[14][3:0] < 4'd4);
    end
    if (et != 16'h0800 || !cfg_l4_en || fr_len < 15) return 1'b0;
    ihl = int'(fr[14][3:0]);
    if (fr[14][7:4] != 4'd4 || ihl < 5 || fr_len < 24 || fr[23] != 8'd17) return 1'b0;
    u = 14 + 4 * ihl;
    if (fr_len < u + 4 || {fr[u+2], fr[u+3]} != 16'd319) return 1'b0;
    if (cfg_sport_chk && {fr[u], fr[u+1]} != 16'd319) return 1'b0;
    p = u + 8;
    if (fr_len < p + 2) return 1'b0;
    if (md == 3) return (fr[p+1][3:0] == 4'd2) && (fr[p][3:0] < 4'd4);
    if (fr[p+1][3:0] != 4'd1 || fr_len < p + 33) return 1'b0;
    return fr[p+32] == ((md == 1) ? 8'd0 : 8'd1);
  endfunction

  task automatic send(input string req);
    bit exp;
    exp = model();
    pulses = 0;
    for (int i = 0; i < fr_len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_first = (i == 0); s_last = (i == fr_len - 1); s_data = fr[i];
    end
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
    #1;
    chk(pulses == 1, {req, " R2 verdict by end"}, pulses, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(pulses == 1, {req, " R2 single verdict"}, pulses, 1);
    chk(last_hit == exp, req, int'(last_hit), int'(exp));
  endtask

  initial begin
    #1_400_000;
    bad++; total++;
    $display("FAIL watchdog R2 actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; pulses = 0; last_hit = 1'b0;
    rst_n = 1'b0; s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0; s_data = 8'h00;
    cfg_mode = 3'd0; cfg_l2_en = 1'b0; cfg_l4_en = 1'b0; cfg_sport_chk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk(pulses == 0 && res_vld == 1'b0 && res_hit == 1'b0, "R1 reset idle", pulses, 0);

    for (int c = 0; c < 64; c++) begin
      cfg_mode = c[2:0]; cfg_l2_en = c[3]; cfg_l4_en = c[4]; cfg_sport_chk = c[5];
      for (int m = 0; m < 5; m++) begin
        mk(16'h88F7, 8'h00, 8'h00, 16'd0, 16'd0, 8'hA0 | 8'(m), 8'h02, 8'h00, 20);
        send("R4 R7 l2 v2 msgtype");
      end
      mk(16'h88F7, 8'h00, 8'h00, 16'd0, 16'd0, 8'h00, 8'h01, 8'h00, 20);
      send("R4 R8 l2 v1 frame");
      for (int m = 2; m < 5; m++) begin
        mk(16'h0800, 8'h45, 8'd17, 16'd319, 16'd319, 8'(m), 8'h02, 8'h00, 78);
        send("R5 R7 l4 v2 msgtype");
      end
      for (int k = 0; k < 3; k++) begin
        mk(16'h0800, 8'h46, 8'd17, 16'd319, 16'd319, 8'h00, 8'h01, 8'(k), 82);
        send("R5 R8 l4 v1 ihl6 ctrl");
        mk(16'h0800, 8'h46, 8'd17, 16'd1000, 16'd319, 8'h00, 8'h01, 8'(k), 82);
        send("R6 sport mismatch");
      end
      mk(16'h0800, 8'h45, 8'd6, 16'd319, 16'd319, 8'h00, 8'h02, 8'h00, 78);
      send("R5 proto not udp");
      mk(16'h0800, 8'h45, 8'd17, 16'd319, 16'd320, 8'h00, 8'h02, 8'h00, 78);
      send("R5 dport 320");
      mk(16'h0800, 8'h44, 8'd17, 16'd319, 16'd319, 8'h00, 8'h02, 8'h00, 78);
      send("R5 ihl 4");
      mk(16'h0800, 8'h65, 8'd17, 16'd319, 16'd319, 8'h00, 8'h02, 8'h00, 78);
      send("R5 ip version 6");
      mk(16'h86DD, 8'h45, 8'd17, 16'd319, 16'd319, 8'h00, 8'h02, 8'h00, 78);
      send("R10 other ethertype");
      mk(16'h88F7, 8'h00, 8'h00, 16'd0, 16'd0, 8'h00, 8'h02, 8'h00, 1);
      send("R3 one byte frame");
    end

    cfg_mode = 3'd1; cfg_l2_en = 1'b1; cfg_l4_en = 1'b1; cfg_sport_chk = 1'b1;
    for (int n = 1; n <= 82; n++) begin
      mk(16'h0800, 8'h45, 8'd17, 16'd319, 16'd319, 8'h00, 8'h01, 8'h00, n);
      send("R9 truncated v1 frame");
    end
    cfg_mode = 3'd3;
    for (int n = 10; n <= 17; n++) begin
      mk(16'h88F7, 8'h00, 8'h00, 16'd0, 16'd0, 8'h03, 8'h02, 8'h00, n);
      send("R9 truncated l2 frame");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule